// File: doc/BRIEF.md
# Round Key Expander

This block turns a user key of 128, 192 or 256 bits into the 33 round keys, each 128 bits wide, used by a 32-round substitution-permutation block cipher. It is sequential. A one-cycle start pulse captures the key and its length code. The block then produces one 32-bit prekey per clock from an affine recurrence over a sliding window of the last eight prekeys. After each group of four prekeys, it substitutes them bitslice-wise through one of eight 4x4 tables, reorders the bits, and writes the result out with its index.

The consumer sees a write port made of a strobe, a 6-bit index and a 128-bit value. The port strobes once for every round key, in ascending order, four cycles apart. A one-cycle done flag follows the last write. Storing the keys and reversing their order for decryption are left to the consumer.

Top module: `rkx_top`

## Requirements
- R1: The key length code `keyLen` selects 128 bits (0), 192 bits (1) or 256 bits (2 or 3). A short key is extended to 256 bits by setting the bit just above its top bit and clearing all higher bits. Any `keyIn` bits at or above the selected length have no effect on the round keys.
- R2: On start, the eight seed prekeys w(-8)..w(-1) are taken from the extended key: w(-8) = bits 31:0, w(-7) = bits 63:32, and so on up to w(-1) = bits 255:224.
- R3: For i = 0..131, prekey w(i) equals w(i-1) xor w(i-3) xor w(i-5) xor w(i-8) xor 0x9E3779B9 xor i, rotated left by 11 bits.
- R4: Round key k is built from the words a = w(4k), b = w(4k+1), c = w(4k+2) and d = w(4k+3). For each column j in 0..31, the nibble {d[j], c[j], b[j], a[j]} (a is the LSB) passes through the selected table. Output bit m of that nibble becomes bit 32m+j of a 128-bit vector. Bit 4j+m of the round key is then bit 32m+j of that vector.
- R5: Round key k uses substitution table number (3 - k) mod 8. So key 0 uses table 3, key 1 uses table 2, key 31 uses table 4 and key 32 uses table 3.
- R6: Counting clock edges from the edge that samples `start`, `rkWe` is high for exactly one cycle after edge 4k+4, carrying `rkIdx` = k and key k, for k = 0..32. `rkWe` is low in every other cycle.
- R7: `done` is high for exactly one cycle, after edge 133, which is the cycle after the write of key 32. It is low at all other times.
- R8: A start pulse during an expansion abandons it. No further key from the old run is written, and the new key's expansion runs with the timing of R6 and R7 counted from the new start edge.
- R9: After reset, `rkWe` and `done` are low and stay low until a start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that captures the key and begins (or restarts) expansion |
| keyIn | input | 256 | User key; only the low 128/192/256 bits are used |
| keyLen | input | 2 | Key length code: 0 = 128, 1 = 192, 2 or 3 = 256 |
| rkWe | output | 1 | Round key write strobe |
| rkIdx | output | 6 | Index of the round key being written |
| rkVal | output | 128 | Round key value |
| done | output | 1 | One-cycle flag after the last round key |

## Verification
Full 256-bit keys with irregular bit patterns exercise the recurrence and every substitution table without any padding involved. The 128-bit and 192-bit cases are run with their unused upper bits set to ones, so that a padding error or leakage from the ignored bits changes keys. An all-zero key makes the prekeys depend only on the constant and the index term, which isolates the recurrence from the key. Code 3 and a restart in the middle of a run check the length decoding and that no stale key escapes after the abandoned run.

// File: rtl/rkx_pkg.sv
package rkx_pkg;

  localparam int WORD_W     = 32;
  localparam int WIN_DEPTH  = 8;
  localparam int NUM_KEYS   = 33;
  localparam int WORDS_PER_KEY = 4;
  localparam int NUM_PRE    = WORDS_PER_KEY * NUM_KEYS;
  localparam int PRE_IDX_W  = $clog2(NUM_PRE);
  localparam int KEY_IDX_W  = PRE_IDX_W - 2;
  localparam int KEY_W      = WORDS_PER_KEY * WORD_W;
  localparam int USER_KEY_W = WIN_DEPTH * WORD_W;
  localparam int ROT_AMT    = 11;
  localparam logic [WORD_W-1:0] GOLDEN = 32'h9E3779B9;

  typedef struct packed {
    logic                 load;
    logic                 advance;
    logic                 emit;
    logic [PRE_IDX_W-1:0] preIdx;
  } step_ctrl_t;

  // Eight 4-bit substitution tables, entry x held in nibble x.
  function automatic logic [3:0] subNibble(input logic [2:0] tbl, input logic [3:0] x);
    logic [63:0] row;
    case (tbl)
      3'd0:    row = 64'hC907_24DE_B56A_1F83;
      3'd1:    row = 64'h43D6_8EB1_A509_72CF;
      3'd2:    row = 64'h25B0_4E1D_FAC3_9768;
      3'd3:    row = 64'hE57A_421D_369C_8BF0;
      3'd4:    row = 64'hD7E9_A452_6B0C_38F1;
      3'd5:    row = 64'h176D_8E30_C9A4_B25F;
      3'd6:    row = 64'h0A3D_F19E_B648_5C27;
      default: row = 64'h6539_AC47_B28E_0FD1;
    endcase
    return row[{x, 2'b00} +: 4];
  endfunction

  // Extend a short key with a marker one and zeros above it.
  function automatic logic [USER_KEY_W-1:0] extendKey(input logic [USER_KEY_W-1:0] k,
                                                      input logic [1:0] len);
    logic [USER_KEY_W-1:0] r;
    case (len)
      2'd0: begin
        r = '0;
        r[127:0] = k[127:0];
        r[128]   = 1'b1;
      end
      2'd1: begin
        r = '0;
        r[191:0] = k[191:0];
        r[192]   = 1'b1;
      end
      default: r = k;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rkx_ctrl.sv
module rkx_ctrl
  import rkx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output step_ctrl_t ctrl,
  output logic       done
);

  localparam logic [PRE_IDX_W-1:0] LAST_STEP = PRE_IDX_W'(NUM_PRE - 1);

  logic                 busy;
  logic [PRE_IDX_W-1:0] stepCnt;
  logic                 finishing;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      stepCnt   <= '0;
      finishing <= 1'b0;
      done      <= 1'b0;
    end else begin
      finishing <= 1'b0;
      done      <= finishing && !start;
      if (start) begin
        busy    <= 1'b1;
        stepCnt <= '0;
      end else if (busy) begin
        if (stepCnt == LAST_STEP) begin
          busy      <= 1'b0;
          finishing <= 1'b1;
        end else begin
          stepCnt <= stepCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctrl.load    = start;
    ctrl.advance = busy && !start;
    ctrl.emit    = busy && !start && (stepCnt[1:0] == 2'b11);
    ctrl.preIdx  = stepCnt;
  end

  // done only ever shows while no expansion is running
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // done never lasts longer than one cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // the step counter stays inside the prekey range while busy
  assert_step_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (stepCnt <= LAST_STEP));

endmodule

// File: rtl/rkx_datapath.sv
module rkx_datapath
  import rkx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  step_ctrl_t            ctrl,
  input  logic [USER_KEY_W-1:0] keyIn,
  input  logic [1:0]            keyLen,
  output logic                  rkWe,
  output logic [KEY_IDX_W-1:0]  rkIdx,
  output logic [KEY_W-1:0]      rkVal
);

  logic [WORD_W-1:0]     win [WIN_DEPTH];
  logic [USER_KEY_W-1:0] seedKey;
  logic [WORD_W-1:0]     mixWord;
  logic [WORD_W-1:0]     newWord;
  logic [WORD_W-1:0]     grp [WORDS_PER_KEY];
  logic [2:0]            tblSel;
  logic [KEY_W-1:0]      sliced;
  logic [KEY_W-1:0]      permuted;

  assign seedKey = extendKey(keyIn, keyLen);

  // recurrence taps: newest is win[7], oldest is win[0]
  assign mixWord = win[WIN_DEPTH-1] ^ win[WIN_DEPTH-3] ^ win[WIN_DEPTH-5] ^ win[0]
                 ^ GOLDEN ^ WORD_W'(ctrl.preIdx);
  assign newWord = (mixWord << ROT_AMT) | (mixWord >> (WORD_W - ROT_AMT));

  // group of four words completed by this step's new word
  assign grp[0] = win[WIN_DEPTH-3];
  assign grp[1] = win[WIN_DEPTH-2];
  assign grp[2] = win[WIN_DEPTH-1];
  assign grp[3] = newWord;

  assign tblSel = 3'd3 - ctrl.preIdx[4:2];

  generate
    for (genvar col = 0; col < WORD_W; col++) begin : g_col
      assign {sliced[3*WORD_W+col], sliced[2*WORD_W+col], sliced[WORD_W+col], sliced[col]} =
        subNibble(tblSel, {grp[3][col], grp[2][col], grp[1][col], grp[0][col]});
      for (genvar m = 0; m < WORDS_PER_KEY; m++) begin : g_bit
        assign permuted[WORDS_PER_KEY*col+m] = sliced[WORD_W*m+col];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int q = 0; q < WIN_DEPTH; q++) win[q] <= '0;
      rkWe  <= 1'b0;
      rkIdx <= '0;
      rkVal <= '0;
    end else begin
      rkWe <= 1'b0;
      if (ctrl.load) begin
        for (int q = 0; q < WIN_DEPTH; q++) win[q] <= seedKey[WORD_W*q +: WORD_W];
      end else if (ctrl.advance) begin
        for (int q = 0; q < WIN_DEPTH-1; q++) win[q] <= win[q+1];
        win[WIN_DEPTH-1] <= newWord;
        if (ctrl.emit) begin
          rkWe  <= 1'b1;
          rkIdx <= ctrl.preIdx[PRE_IDX_W-1:2];
          rkVal <= permuted;
        end
      end
    end
  end

  // writes are spaced: a write cycle is never followed by another
  assert_write_spacing_R6: assert property (@(posedge clk) disable iff (!rstN)
    rkWe |=> !rkWe);

  // a written index always names an existing round key
  assert_index_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    rkWe |-> (rkIdx < KEY_IDX_W'(NUM_KEYS)));

  // a (re)start suppresses any write in the following cycle
  assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> !rkWe);

endmodule

// File: rtl/rkx_top.sv
module rkx_top
  import rkx_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [255:0] keyIn,
  input  logic [1:0]   keyLen,
  output logic         rkWe,
  output logic [5:0]   rkIdx,
  output logic [127:0] rkVal,
  output logic         done
);

  step_ctrl_t ctrl;

  rkx_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl),
    .done  (done)
  );

  rkx_datapath u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .keyIn  (keyIn),
    .keyLen (keyLen),
    .rkWe   (rkWe),
    .rkIdx  (rkIdx),
    .rkVal  (rkVal)
  );

endmodule

// File: tb/rkx_top_bench.sv
`timescale 1ns/1ps
module rkx_top_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [255:0] keyIn = '0;
  logic [1:0]   keyLen = 2'd0;
  logic         rkWe;
  logic [5:0]   rkIdx;
  logic [127:0] rkVal;
  logic         done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [127:0] expKey [33];

  int sbTab [8][16] = '{
    '{3, 8,15, 1,10, 6, 5,11,14,13, 4, 2, 7, 0, 9,12},
    '{15,12, 2, 7, 9, 0, 5,10, 1,11,14, 8, 6,13, 3, 4},
    '{8, 6, 7, 9, 3,12,10,15,13, 1,14, 4, 0,11, 5, 2},
    '{0,15,11, 8,12, 9, 6, 3,13, 1, 2, 4,10, 7, 5,14},
    '{1,15, 8, 3,12, 0,11, 6, 2, 5, 4,10, 9,14, 7,13},
    '{15, 5, 2,11, 4,10, 9,12, 0, 3,14, 8,13, 6, 7, 1},
    '{7, 2,12, 5, 8, 4, 6,11,14, 9, 1,15,13, 3,10, 0},
    '{1,13,15, 0,14, 8, 2,11, 7, 4,12,10, 9, 3, 5, 6}
  };

  always #2 clk = ~clk;

  rkx_top u_rkx_top (
    .clk(clk), .rstN(rstN), .start(start), .keyIn(keyIn), .keyLen(keyLen),
    .rkWe(rkWe), .rkIdx(rkIdx), .rkVal(rkVal), .done(done)
  );

  // behavioural model of the whole expansion
  task automatic buildModel(input logic [255:0] k, input logic [1:0] len);
    logic [255:0] p;
    logic [31:0]  w [140];
    logic [31:0]  t;
    logic [127:0] raw;
    int bits;
    bits = (len == 2'd0) ? 128 : (len == 2'd1) ? 192 : 256;
    for (int b = 0; b < 256; b++) p[b] = (b < bits) ? k[b] : (b == bits);
    for (int q = 0; q < 8; q++) w[q] = p[32*q +: 32];
    for (int i = 0; i < 132; i++) begin
      t = w[i+7] ^ w[i+5] ^ w[i+3] ^ w[i] ^ 32'h9E3779B9 ^ 32'(i);
      w[i+8] = (t << 11) | (t >> 21);
    end
    for (int kk = 0; kk < 33; kk++) begin
      int tb;
      int base;
      tb = (((3 - kk) % 8) + 8) % 8;
      base = 8 + 4*kk;
      for (int j = 0; j < 32; j++) begin
        int nib;
        int o;
        nib = w[base][j] + 2*w[base+1][j] + 4*w[base+2][j] + 8*w[base+3][j];
        o = sbTab[tb][nib];
        for (int m = 0; m < 4; m++) raw[32*m+j] = o[m];
      end
      for (int i = 0; i < 128; i++)
        expKey[kk][i] = (i == 127) ? raw[127] : raw[(32*i) % 127];
    end
  endtask

  task automatic note(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // drive a start pulse; returns just after the sampling edge (cycle 0)
  task automatic kick(input logic [255:0] k, input logic [1:0] len);
    buildModel(k, len);
    keyIn = k;
    keyLen = len;
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    note(rkWe == 1'b0, "R8", "write right after start", 128'(rkWe), 128'(0));
  endtask

  // check cycles 1..last after the start edge
  task automatic follow(input int last, input string valTag);
    for (int n = 1; n <= last; n++) begin
      bit expWe;
      bit expDone;
      @(posedge clk);
      #1;
      expWe = (n >= 4) && (n % 4 == 0) && (n <= 132);
      expDone = (n == 133);
      note(rkWe == expWe, "R6", $sformatf("write strobe at cycle %0d", n),
           128'(rkWe), 128'(expWe));
      note(done == expDone, "R7", $sformatf("done at cycle %0d", n),
           128'(done), 128'(expDone));
      if (expWe && rkWe) begin
        note(rkIdx == 6'(n/4 - 1), "R6", "key index", 128'(rkIdx), 128'(n/4 - 1));
        note(rkVal == expKey[n/4 - 1], valTag,
             $sformatf("round key %0d", n/4 - 1), rkVal, expKey[n/4 - 1]);
      end
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    note(rkWe == 1'b0, "R9", "write strobe in reset", 128'(rkWe), 128'(0));
    note(done == 1'b0, "R9", "done in reset", 128'(done), 128'(0));
    rstN = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(posedge clk);
      #1;
      note(rkWe == 1'b0 && done == 1'b0, "R9", "idle outputs before start",
           128'({rkWe, done}), 128'(0));
    end

    // full-length key, R2 R3 R4 R5
    kick(256'h0123456789ABCDEF_FEDCBA9876543210_A5A5C3C3_0F0F1E1E_DEADBEEF_13579BDF, 2'd2);
    follow(136, "R2 R3 R4 R5");

    // 192-bit key with set ignored upper bits, R1
    kick({64'hFFFF_FFFF_FFFF_FFFF, 192'h8899AABBCCDDEEFF_0011223344556677_1020304050607080}, 2'd1);
    follow(136, "R1 R4");

    // 128-bit key with set ignored upper bits, R1
    kick({128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 128'h000102030405060708090A0B0C0D0E0F}, 2'd0);
    follow(136, "R1 R5");

    // all-zero key, 128-bit and 256-bit, R3
    kick('0, 2'd0);
    follow(136, "R1 R3");
    kick('0, 2'd2);
    follow(136, "R2 R3");

    // length code 3 behaves as 256 bits, R1
    kick({8{32'hC001D00D}}, 2'd3);
    follow(136, "R1 R4");

    // restart in mid-run, R8
    kick({8{32'h5A5A0001}}, 2'd2);
    follow(49, "R3 R4");
    kick({4{64'h0F1E2D3C4B5A6978}}, 2'd1);
    follow(136, "R8");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule